// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame is kept, using only its 48-bit destination address and a small set of configuration registers. The receive path presents the destination address with a one-cycle strobe. One clock later the filter returns an accept flag and a 2-bit code that names the rule which produced the decision. Frame reception, CRC and data movement belong to other blocks.

Configuration is held in four 32-bit registers, all on one write port and one combinational read port. A control register holds five policy flags. An entry-enable register arms the single station-address entry. Two registers carry the 48-bit station address, most significant byte first. The flags are: take broadcast, take multicast, take every unicast, compare unicast against the station entry, and invert the compare. The invert flag flips the unicast match result, and it also admits every broadcast and multicast frame.

Top module: `dafilt_top`

## Requirements
- R1: After reset, res_valid and res_accept are 0, res_why is 0, and all four registers read as zero.
- R2: A destination with all 48 bits set is broadcast. It is accepted when the invert flag (control bit 4) or the take-broadcast flag (control bit 2) is set, and it reports res_why = 2'b11.
- R3: A destination with bit 40 set (the low bit of the first byte, which sits in bits 47:40) that is not broadcast is multicast. It is accepted when the invert flag or the take-multicast flag (control bit 1) is set, and it reports res_why = 2'b10.
- R4: A unicast destination (bit 40 clear) is always accepted when the take-every-unicast flag (control bit 0) is set, and it reports res_why = 2'b01.
- R5: Otherwise a unicast destination reports res_why = 2'b00. Its match is true only when the compare flag (control bit 3) is set, the entry enable is set, and the destination equals the station address. It is accepted when the match differs from the invert flag.
- R6: Select 2 (station high) supplies station bits 47:16 from write data 31:0. Select 3 (station low) supplies station bits 15:0 from write data 31:16. Select 3 reads back as {bits 15:0, 16'h0}, and the low write half has no effect.
- R7: At select 1 (entry enable) only data bit 0 is stored, and the register reads as {31'b0, bit}. At select 0 (control) only bits 4:0 are stored, and the other bits read as zero.
- R8: res_valid rises exactly one cycle after each dst_valid cycle and lasts one cycle. While res_valid is low, res_accept and res_why are 0.
- R9: A register write in the same cycle as dst_valid affects only later strobes. The decision for that strobe uses the settings held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wsel | input | 2 | Write select: 0 control, 1 entry enable, 2 station high, 3 station low |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 2 | Read select, same encoding |
| cfg_rdata | output | 32 | Read data of the selected register |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first byte in bits 47:40 |
| res_valid | output | 1 | Decision strobe, one cycle after dst_valid |
| res_accept | output | 1 | Frame accepted |
| res_why | output | 2 | Deciding rule: 00 compare, 01 all-unicast, 10 multicast, 11 broadcast |

## Verification
A register write and an address decision can fall in the same clock cycle. The bench provokes this by raising dst_valid in the same cycle as a control or entry-enable write that would reverse the outcome. It then checks that this decision follows the old settings and that the next strobe follows the new ones. The main sweep covers every control value with the entry enable both off and on, against broadcast, multicast, near-broadcast and unicast addresses that differ from the station address in the first or last byte.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  localparam int MAC_W = 48;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    WHY_UCMP  = 2'b00,
    WHY_UALL  = 2'b01,
    WHY_MCAST = 2'b10,
    WHY_BCAST = 2'b11
  } why_e;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_ENTRY  = 2'd1,
    SEL_STA_HI = 2'd2,
    SEL_STA_LO = 2'd3
  } sel_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic cmp_inv;
    logic cmp_en;
    logic take_bc;
    logic take_mc;
    logic take_uni;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
  import dafilt_pkg::*;
#(
  parameter int MAC_BITS = MAC_W,
  parameter int DATA_W   = REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_wsel,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic [1:0]          cfg_rsel,
  output logic [DATA_W-1:0]   cfg_rdata,
  output ctrl_t               ctrl,
  output logic                entry_en,
  output logic [MAC_BITS-1:0] station
);
  localparam int HI_W = DATA_W;
  localparam int LO_W = MAC_BITS - DATA_W;

  ctrl_t           ctrl_q, ctrl_d;
  logic            en_q, en_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic            wr_ctrl, wr_en, wr_hi, wr_lo;

  always_comb begin
    wr_ctrl = cfg_we && (cfg_wsel == SEL_CTRL);
    wr_en   = cfg_we && (cfg_wsel == SEL_ENTRY);
    wr_hi   = cfg_we && (cfg_wsel == SEL_STA_HI);
    wr_lo   = cfg_we && (cfg_wsel == SEL_STA_LO);
    ctrl_d  = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    en_d    = cfg_wdata[0];
    hi_d    = cfg_wdata[HI_W-1:0];
    lo_d    = cfg_wdata[DATA_W-1 -: LO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_en)   en_q   <= en_d;
      if (wr_hi)   hi_q   <= hi_d;
      if (wr_lo)   lo_q   <= lo_d;
    end
  end

  always_comb begin
    unique case (cfg_rsel)
      SEL_CTRL:   cfg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      SEL_ENTRY:  cfg_rdata = {{(DATA_W-1){1'b0}}, en_q};
      SEL_STA_HI: cfg_rdata = hi_q;
      default:    cfg_rdata = {lo_q, {(DATA_W-LO_W){1'b0}}};
    endcase
  end

  assign ctrl     = ctrl_q;
  assign entry_en = en_q;
  assign station  = {hi_q, lo_q};
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
  import dafilt_pkg::*;
#(
  parameter int MAC_BITS = MAC_W
) (
  input  logic [MAC_BITS-1:0] dst,
  input  ctrl_t               ctrl,
  input  logic                entry_en,
  input  logic [MAC_BITS-1:0] station,
  output logic                accept,
  output why_e                why
);
  localparam int NBYTES = MAC_BITS / 8;
  localparam int GRP_BIT = MAC_BITS - 8;

  logic [NBYTES-1:0] byte_eq;
  logic is_bc, is_mc, addr_eq, match;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_eq[b] = (dst[8*b +: 8] == station[8*b +: 8]);
  end

  always_comb begin
    is_bc   = &dst;
    is_mc   = dst[GRP_BIT] && !is_bc;
    addr_eq = &byte_eq;
    match   = ctrl.cmp_en && entry_en && addr_eq;
    if (is_bc) begin
      why    = WHY_BCAST;
      accept = ctrl.cmp_inv || ctrl.take_bc;
    end else if (is_mc) begin
      why    = WHY_MCAST;
      accept = ctrl.cmp_inv || ctrl.take_mc;
    end else if (ctrl.take_uni) begin
      why    = WHY_UALL;
      accept = 1'b1;
    end else begin
      why    = WHY_UCMP;
      accept = match ^ ctrl.cmp_inv;
    end
  end
endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
  import dafilt_pkg::*;
#(
  parameter int MAC_BITS = MAC_W,
  parameter int DATA_W   = REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_wsel,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic [1:0]          cfg_rsel,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                dst_valid,
  input  logic [MAC_BITS-1:0] dst_addr,
  output logic                res_valid,
  output logic                res_accept,
  output logic [1:0]          res_why
);
  ctrl_t               cur_ctrl;
  logic                cur_en;
  logic [MAC_BITS-1:0] cur_station;
  logic                dec_accept;
  why_e                dec_why;

  logic       vld_q, vld_d;
  logic       acc_q, acc_d;
  logic [1:0] why_q, why_d;

  dafilt_regs #(.MAC_BITS(MAC_BITS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_wdata(cfg_wdata),
    .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .ctrl(cur_ctrl), .entry_en(cur_en), .station(cur_station)
  );

  dafilt_decide #(.MAC_BITS(MAC_BITS)) u_decide (
    .dst(dst_addr), .ctrl(cur_ctrl), .entry_en(cur_en),
    .station(cur_station), .accept(dec_accept), .why(dec_why)
  );

  always_comb begin
    vld_d = dst_valid;
    acc_d = dst_valid && dec_accept;
    why_d = dst_valid ? dec_why : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      why_q <= 2'b00;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
      why_q <= why_d;
    end
  end

  assign res_valid  = vld_q;
  assign res_accept = acc_q;
  assign res_why    = why_q;
endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk #(
  parameter int MAC_BITS = 48
) (
  input logic                clk,
  input logic                rst_n,
  input logic                dst_valid,
  input logic [MAC_BITS-1:0] dst_addr,
  input logic                res_valid,
  input logic                res_accept,
  input logic [1:0]          res_why,
  input logic [1:0]          cfg_rsel,
  input logic [31:0]         cfg_rdata,
  input logic [4:0]          ctrl
);
  logic grp, bc;
  assign grp = dst_addr[MAC_BITS-8];
  assign bc  = &dst_addr;

  a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> res_valid);
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !res_valid);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_accept && res_why == 2'b00));
  a_r2_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && bc) |=> (res_why == 2'b11 && res_accept == ($past(ctrl[4]) || $past(ctrl[2]))));
  a_r3_inv_mc: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && grp && !bc && ctrl[4]) |=> (res_accept && res_why == 2'b10));
  a_r4_all_uni: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !grp && ctrl[0]) |=> (res_accept && res_why == 2'b01));
  a_r5_no_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !grp && !ctrl[0] && !ctrl[3]) |=> (res_accept == $past(ctrl[4]) && res_why == 2'b00));
  a_r7_entry_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rsel == 2'd1) |-> (cfg_rdata[31:1] == '0));
endmodule

bind dafilt_top dafilt_chk #(.MAC_BITS(MAC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
  .res_valid(res_valid), .res_accept(res_accept), .res_why(res_why),
  .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata), .ctrl(cur_ctrl)
);

// File: tb/tb_dafilt_top.sv
module tb_dafilt_top;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_wsel, cfg_rsel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        dst_valid;
  logic [47:0] dst_addr;
  logic        res_valid, res_accept;
  logic [1:0]  res_why;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [47:0] STA = 48'h02A1B2C3D4E5;

  dafilt_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .res_valid(res_valid),
    .res_accept(res_accept), .res_why(res_why)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    cfg_rsel = sel;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  // independent model of the policy
  function automatic logic [2:0] model(input logic [4:0] c, input logic en, input logic [47:0] a);
    logic acc;
    logic [1:0] why;
    if (a == 48'hFFFF_FFFF_FFFF) begin
      why = 2'b11; acc = c[4] | c[2];
    end else if (a[40]) begin
      why = 2'b10; acc = c[4] | c[1];
    end else if (c[0]) begin
      why = 2'b01; acc = 1'b1;
    end else begin
      why = 2'b00; acc = (c[3] & en & (a == STA)) ^ c[4];
    end
    return {acc, why};
  endfunction

  task automatic frame(input logic [47:0] a, input logic [2:0] exp, input string tag);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a;
    @(negedge clk);
    dst_valid = 1'b0;
    check({tag, " valid"}, {31'b0, res_valid}, 32'd1);
    check({tag, " decision"}, {29'b0, res_accept, res_why}, {29'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] addrs [6];
    addrs[0] = 48'hFFFF_FFFF_FFFF;
    addrs[1] = 48'h0100_5E00_0001;
    addrs[2] = 48'hFFFF_FFFF_FFFE;
    addrs[3] = STA;
    addrs[4] = 48'h02A1_B2C3_D4E4;
    addrs[5] = 48'h00A1_B2C3_D4E5;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wsel = '0; cfg_wdata = '0;
    cfg_rsel = '0; dst_valid = 1'b0; dst_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 res_valid", {31'b0, res_valid}, 0);
    check("R1 res_accept", {31'b0, res_accept}, 0);
    check("R1 res_why", {30'b0, res_why}, 0);
    for (int s = 0; s < 4; s++) rd(s[1:0], 32'h0, "R1 reg reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", {31'b0, res_valid}, 0);

    // R6 station packing and low-half discard
    wr(2'd2, 32'h02A1B2C3);
    wr(2'd3, 32'hD4E59F3C);
    rd(2'd2, 32'h02A1B2C3, "R6 station high");
    rd(2'd3, 32'hD4E50000, "R6 station low");
    // R7 only implemented bits stored
    wr(2'd1, 32'hFFFF_FFFE);
    rd(2'd1, 32'h0, "R7 entry bit0 clear");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h1, "R7 entry bit0 only");
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h1F, "R7 control width");

    // Sweep R2 R3 R4 R5 over every control value and both enables
    for (int en = 0; en < 2; en++) begin
      wr(2'd1, en);
      for (int c = 0; c < 32; c++) begin
        wr(2'd0, c);
        for (int k = 0; k < 6; k++) begin
          logic [2:0] e;
          e = model(c[4:0], en[0], addrs[k]);
          if (k == 0) frame(addrs[k], e, "R2 broadcast");
          else if (k < 3) frame(addrs[k], e, "R3 multicast");
          else if (c[0]) frame(addrs[k], e, "R4 all unicast");
          else frame(addrs[k], e, "R5 unicast compare");
        end
      end
    end

    // R8 single pulse
    @(negedge clk);
    check("R8 pulse ends", {31'b0, res_valid}, 0);
    check("R8 idle accept", {29'b0, res_accept, res_why}, 0);

    // R9 write concurrent with strobe: ctrl 0x08 (compare), entry on
    wr(2'd1, 1);
    wr(2'd0, 32'h08);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = STA;
    cfg_we = 1'b1; cfg_wsel = 2'd0; cfg_wdata = 32'h18; // add invert
    @(negedge clk);
    dst_valid = 1'b0; cfg_we = 1'b0;
    check("R9 old settings used", {29'b0, res_accept, res_why}, {29'b0, 3'b100});
    frame(STA, 3'b000, "R9 new settings later");
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = STA;
    cfg_we = 1'b1; cfg_wsel = 2'd1; cfg_wdata = 32'h0; // disarm entry
    @(negedge clk);
    dst_valid = 1'b0; cfg_we = 1'b0;
    check("R9 old entry used", {29'b0, res_accept, res_why}, {29'b0, 3'b000});
    frame(STA, 3'b100, "R9 entry off later");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule